// File: doc/BRIEF.md
# Run Stop Step Controller

This block decides when an 8-bit processor core may make progress. It drives a single ready line into the core: low holds the core in its wait state, high lets it go on. Operator requests for run, stop, single step and slow pacing arrive already debounced. The core reports the start of every machine cycle with a one-clock strobe, and a status flag that marks the first cycle of an instruction. From these inputs the block keeps the machine either halted under panel control or running freely.

When halted, the block holds the core waiting and tells the rest of the panel logic that its functions may act. A step press releases the core for one machine cycle or for one whole instruction, as an option input selects, and then holds it again. Holding the slow input repeats such steps at a rate derived from the system clock by a divider, about two per second with the default parameters. A run press releases the core until a stop press, and the stop takes effect at the next machine-cycle start. The panel reset request is passed to the core in every mode, one clock later.

Top module: `runStepCtl`

## Requirements
- R1: After power-up reset, and whenever the block is halted, panelEn is 1, runMode is 0 and coreReady is 0.
- R2: A rising edge of runReq while halted sets runMode and coreReady to 1 and panelEn to 0 one clock later.
- R3: While running, rising edges of runReq, stepReq and slowIn have no effect, and coreReady stays 1.
- R4: A stopReq rising edge while running is remembered until the next cycleStart. One clock after that cycleStart is sampled, runMode and coreReady are 0 and panelEn is 1. Without a cycleStart the block keeps running.
- R5: With instrGran at 0, a stepReq rising edge while halted sets coreReady one clock later. coreReady drops one clock after the first cycleStart, whatever the value of m1Flag.
- R6: With instrGran at 1, a step ends only at a cycleStart that has m1Flag at 1. Cycle starts with m1Flag at 0 leave coreReady at 1.
- R7: Step requests are edge detected. Holding stepReq high gives one step only, and a new step needs a fresh rising edge.
- R8: A slowIn rising edge while halted releases one step at once and restarts a divider of SLOW_DIV = CLK_HZ/SLOW_HZ clocks. While slowIn stays high, each divider wrap releases one more step if the previous step has ended. Each step ends by the same boundary rule as R5 and R6.
- R9: After slowIn falls, no new step is released. The block returns to halted as soon as no step is in progress.
- R10: coreResetOut equals panelReset delayed by one clock in every mode, and panelReset never changes the mode.
- R11: When several requests rise in the same clock while halted, run has priority over step, and step has priority over slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| runReq | input | 1 | Debounced run request |
| stopReq | input | 1 | Debounced stop request |
| stepReq | input | 1 | Debounced single-step request |
| slowIn | input | 1 | Debounced slow-pacing level, held by the operator |
| panelReset | input | 1 | Panel reset request for the core |
| instrGran | input | 1 | 1 steps whole instructions, 0 steps machine cycles |
| cycleStart | input | 1 | One-clock strobe at the start of each core machine cycle |
| m1Flag | input | 1 | Status: the cycle that is starting is the first of an instruction |
| coreReady | output | 1 | 1 lets the core proceed, 0 holds it in wait |
| runMode | output | 1 | Block is in free-running mode |
| panelEn | output | 1 | Panel functions may act (halted) |
| coreResetOut | output | 1 | Registered panel reset toward the core |

## Verification
The hardest case to reach is the slow mode where the divider wrap and the end of a step fall in different orders. A wrap may arrive while a step is still waiting for its boundary, and slowIn may fall part way through a step. The stimulus holds slowIn over several divider periods and emits cycle starts at irregular gaps, some shorter and some longer than the divider. It mixes M1 and non-M1 starts under both granularities, then drops slowIn in the middle of a step. A behavioural model that runs in step with the design checks every clock of this sequence.

// File: rtl/runStepPkg.sv
package runStepPkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_STEP = 2'd2,
    MODE_SLOW = 2'd3
  } modeT;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic setRelease;
    logic clrRelease;
    logic clrDivider;
  } ctlStrobeT;

  // Conditions from the datapath to the control FSM.
  typedef struct packed {
    logic runRise;
    logic stopRise;
    logic stepRise;
    logic slowRise;
    logic slowLevel;
    logic cycleEdge;
    logic boundary;
    logic divTick;
    logic releaseOn;
  } dpStatusT;

  localparam int unsigned REQ_COUNT = 4;

endpackage

// File: rtl/runStepDp.sv
module runStepDp
  import runStepPkg::*;
#(
  parameter int unsigned DIV_COUNT = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      runReq,
  input  logic      stopReq,
  input  logic      stepReq,
  input  logic      slowIn,
  input  logic      panelReset,
  input  logic      instrGran,
  input  logic      cycleStart,
  input  logic      m1Flag,
  input  ctlStrobeT ctl,
  output dpStatusT  status,
  output logic      coreReady,
  output logic      coreResetOut
);

  localparam int unsigned CNT_W = (DIV_COUNT < 2) ? 1 : $clog2(DIV_COUNT);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_COUNT - 1);

  // Request order in the vector: [3] run, [2] stop, [1] step, [0] slow
  logic [REQ_COUNT-1:0] reqNow;
  logic [REQ_COUNT-1:0] reqPrev;
  logic [REQ_COUNT-1:0] reqRise;

  assign reqNow = {runReq, stopReq, stepReq, slowIn};

  for (genvar gi = 0; gi < REQ_COUNT; gi++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) reqPrev[gi] <= 1'b0;
      else       reqPrev[gi] <= reqNow[gi];
    end
    assign reqRise[gi] = reqNow[gi] & ~reqPrev[gi];
  end

  // Slow-rate divider
  logic [CNT_W-1:0] divCnt;
  logic             divTick;

  assign divTick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               divCnt <= '0;
    else if (ctl.clrDivider) divCnt <= '0;
    else if (divTick)        divCnt <= '0;
    else                     divCnt <= divCnt + 1'b1;
  end

  // Release flag: drives the core ready line
  logic releaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               releaseQ <= 1'b0;
    else if (ctl.clrRelease) releaseQ <= 1'b0;
    else if (ctl.setRelease) releaseQ <= 1'b1;
  end

  // Reset passthrough toward the core
  logic resetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetQ <= 1'b0;
    else       resetQ <= panelReset;
  end

  logic boundary;
  assign boundary = cycleStart & (~instrGran | m1Flag);

  always_comb begin
    status.runRise   = reqRise[3];
    status.stopRise  = reqRise[2];
    status.stepRise  = reqRise[1];
    status.slowRise  = reqRise[0];
    status.slowLevel = slowIn;
    status.cycleEdge = cycleStart;
    status.boundary  = boundary;
    status.divTick   = divTick;
    status.releaseOn = releaseQ;
  end

  assign coreReady    = releaseQ;
  assign coreResetOut = resetQ;

endmodule

// File: rtl/runStepFsm.sv
module runStepFsm
  import runStepPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStatusT  status,
  output ctlStrobeT ctl,
  output logic      runMode,
  output logic      panelEn
);

  modeT modeQ;
  modeT modeD;
  logic stopPendQ;
  logic stopPendD;

  always_comb begin
    modeD     = modeQ;
    stopPendD = stopPendQ;
    ctl       = '0;
    unique case (modeQ)
      MODE_STOP: begin
        if (status.runRise) begin
          ctl.setRelease = 1'b1;
          modeD          = MODE_RUN;
        end else if (status.stepRise) begin
          ctl.setRelease = 1'b1;
          modeD          = MODE_STEP;
        end else if (status.slowRise) begin
          ctl.setRelease = 1'b1;
          ctl.clrDivider = 1'b1;
          modeD          = MODE_SLOW;
        end
      end
      MODE_RUN: begin
        if (status.stopRise || stopPendQ) begin
          if (status.cycleEdge) begin
            ctl.clrRelease = 1'b1;
            stopPendD      = 1'b0;
            modeD          = MODE_STOP;
          end else begin
            stopPendD = 1'b1;
          end
        end
      end
      MODE_STEP: begin
        if (status.boundary) begin
          ctl.clrRelease = 1'b1;
          modeD          = MODE_STOP;
        end
      end
      MODE_SLOW: begin
        if (status.releaseOn) begin
          if (status.boundary) begin
            ctl.clrRelease = 1'b1;
            if (!status.slowLevel) modeD = MODE_STOP;
          end
        end else if (!status.slowLevel) begin
          modeD = MODE_STOP;
        end else if (status.divTick) begin
          ctl.setRelease = 1'b1;
        end
      end
      default: modeD = MODE_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_STOP;
      stopPendQ <= 1'b0;
    end else begin
      modeQ     <= modeD;
      stopPendQ <= stopPendD;
    end
  end

  assign runMode = (modeQ == MODE_RUN);
  assign panelEn = (modeQ == MODE_STOP);

endmodule

// File: rtl/runStepCtl.sv
module runStepCtl
  import runStepPkg::*;
#(
  parameter int unsigned CLK_HZ  = 2_000_000,
  parameter int unsigned SLOW_HZ = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic runReq,
  input  logic stopReq,
  input  logic stepReq,
  input  logic slowIn,
  input  logic panelReset,
  input  logic instrGran,
  input  logic cycleStart,
  input  logic m1Flag,
  output logic coreReady,
  output logic runMode,
  output logic panelEn,
  output logic coreResetOut
);

  localparam int unsigned SLOW_DIV = (CLK_HZ / SLOW_HZ < 2) ? 2 : CLK_HZ / SLOW_HZ;

  ctlStrobeT ctl;
  dpStatusT  status;

  runStepDp #(.DIV_COUNT(SLOW_DIV)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .runReq       (runReq),
    .stopReq      (stopReq),
    .stepReq      (stepReq),
    .slowIn       (slowIn),
    .panelReset   (panelReset),
    .instrGran    (instrGran),
    .cycleStart   (cycleStart),
    .m1Flag       (m1Flag),
    .ctl          (ctl),
    .status       (status),
    .coreReady    (coreReady),
    .coreResetOut (coreResetOut)
  );

  runStepFsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .status  (status),
    .ctl     (ctl),
    .runMode (runMode),
    .panelEn (panelEn)
  );

endmodule

// File: rtl/runStepChk.sv
module runStepChk (
  input logic clk,
  input logic rstN,
  input logic coreReady,
  input logic runMode,
  input logic panelEn,
  input logic instrGran,
  input logic cycleStart,
  input logic m1Flag
);

  // R1
  halted_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    panelEn |-> !coreReady);

  // R3
  run_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    runMode |-> coreReady);

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && !cycleStart) |=> runMode);

  // R5
  cycle_step_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReady && !runMode && !instrGran && cycleStart) |=> !coreReady);

  // R6
  instr_step_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReady && !runMode && instrGran && cycleStart && m1Flag) |=> !coreReady);

  // R6
  instr_step_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReady && !runMode && instrGran && cycleStart && !m1Flag) |=> coreReady);

endmodule

bind runStepCtl runStepChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .coreReady  (coreReady),
  .runMode    (runMode),
  .panelEn    (panelEn),
  .instrGran  (instrGran),
  .cycleStart (cycleStart),
  .m1Flag     (m1Flag)
);

// File: tb/sim_runStepCtl.sv
module sim_runStepCtl;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 16;
  localparam int TB_SLOW_HZ = 2;
  localparam int DIV        = TB_CLK_HZ / TB_SLOW_HZ;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runReq = 0, stopReq = 0, stepReq = 0, slowIn = 0, panelReset = 0;
  logic instrGran = 0, cycleStart = 0, m1Flag = 0;
  logic coreReady, runMode, panelEn, coreResetOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  runStepCtl #(.CLK_HZ(TB_CLK_HZ), .SLOW_HZ(TB_SLOW_HZ)) u0 (
    .clk(clk), .rstN(rstN), .runReq(runReq), .stopReq(stopReq),
    .stepReq(stepReq), .slowIn(slowIn), .panelReset(panelReset),
    .instrGran(instrGran), .cycleStart(cycleStart), .m1Flag(m1Flag),
    .coreReady(coreReady), .runMode(runMode), .panelEn(panelEn),
    .coreResetOut(coreResetOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  string curReq = "R1";
  bit finished = 0;

  // Behavioural reference: mode 0 halted, 1 running, 2 stepping, 3 slow
  int mMode = 0, mRdy = 0, mPend = 0, mDiv = 0, mRst = 0;
  int pRun = 0, pStop = 0, pStep = 0, pSlow = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mRdy = 0; mPend = 0; mDiv = 0; mRst = 0;
      pRun = 0; pStop = 0; pStep = 0; pSlow = 0;
    end else begin
      int upRun, upStop, upStep, upSlow, endsStep, wrap, restart;
      upRun  = (runReq && !pRun) ? 1 : 0;
      upStop = (stopReq && !pStop) ? 1 : 0;
      upStep = (stepReq && !pStep) ? 1 : 0;
      upSlow = (slowIn && !pSlow) ? 1 : 0;
      endsStep = (cycleStart && (!instrGran || m1Flag)) ? 1 : 0;
      wrap = (mDiv == DIV - 1) ? 1 : 0;
      restart = 0;
      if (mMode == 0) begin
        if (upRun != 0)       begin mRdy = 1; mMode = 1; end
        else if (upStep != 0) begin mRdy = 1; mMode = 2; end
        else if (upSlow != 0) begin mRdy = 1; mMode = 3; restart = 1; end
      end else if (mMode == 1) begin
        if (upStop != 0 || mPend != 0) begin
          if (cycleStart) begin mRdy = 0; mMode = 0; mPend = 0; end
          else mPend = 1;
        end
      end else if (mMode == 2) begin
        if (endsStep != 0) begin mRdy = 0; mMode = 0; end
      end else begin
        if (mRdy != 0) begin
          if (endsStep != 0) begin
            mRdy = 0;
            if (!slowIn) mMode = 0;
          end
        end else if (!slowIn) mMode = 0;
        else if (wrap != 0) mRdy = 1;
      end
      if (restart != 0 || wrap != 0) mDiv = 0;
      else mDiv = mDiv + 1;
      pRun = runReq; pStop = stopReq; pStep = stepReq; pSlow = slowIn;
      mRst = panelReset;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(curReq, "coreReady", coreReady, mRdy[0]);
      chk(curReq, "runMode", runMode, (mMode == 1));
      chk(curReq, "panelEn", panelEn, (mMode == 0));
      chk("R10", "coreResetOut", coreResetOut, mRst[0]);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic cyc(logic isM1);
    @(negedge clk); cycleStart = 1'b1; m1Flag = isM1;
    @(negedge clk); cycleStart = 1'b0; m1Flag = 1'b0;
  endtask

  int wdCount = 0;
  always @(posedge clk) begin
    wdCount++;
    if (wdCount > 20000 && !finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state
    curReq = "R1";
    @(negedge clk);
    chk("R1", "reset panelEn", panelEn, 1'b1);
    chk("R1", "reset coreReady", coreReady, 1'b0);

    // R10 reset passthrough while halted
    curReq = "R10";
    pulse(panelReset);
    chk("R10", "mode kept halted", panelEn, 1'b1);
    idle(2);

    // R2 run
    curReq = "R2";
    @(negedge clk) runReq = 1'b1;
    @(negedge clk) runReq = 1'b0;
    chk("R2", "run coreReady", coreReady, 1'b1);
    chk("R2", "runMode", runMode, 1'b1);

    // R3 ignored while running; R10 reset in run
    curReq = "R3";
    pulse(stepReq); pulse(slowIn); pulse(runReq); pulse(panelReset);
    cyc(1'b1); cyc(1'b0);
    chk("R3", "still running", runMode, 1'b1);
    chk("R3", "still ready", coreReady, 1'b1);

    // R4 stop deferred to cycle start
    curReq = "R4";
    pulse(stopReq);
    idle(4);
    chk("R4", "pending, still running", runMode, 1'b1);
    cyc(1'b0);
    chk("R4", "stopped after cycle start", coreReady, 1'b0);
    chk("R4", "panel enabled", panelEn, 1'b1);
    // stop rising together with cycle start
    pulse(runReq); idle(2);
    @(negedge clk); stopReq = 1; cycleStart = 1;
    @(negedge clk); stopReq = 0; cycleStart = 0;
    chk("R4", "same-cycle stop", runMode, 1'b0);

    // R5 machine-cycle step
    curReq = "R5";
    instrGran = 1'b0;
    pulse(stepReq);
    chk("R5", "step released", coreReady, 1'b1);
    idle(3);
    cyc(1'b0);
    chk("R5", "step ended at non-M1 start", coreReady, 1'b0);

    // R6 instruction step
    curReq = "R6";
    instrGran = 1'b1;
    pulse(stepReq);
    cyc(1'b0); cyc(1'b0);
    chk("R6", "non-M1 starts keep ready", coreReady, 1'b1);
    cyc(1'b1);
    chk("R6", "M1 start ends step", coreReady, 1'b0);

    // R7 held step gives one step
    curReq = "R7";
    instrGran = 1'b0;
    @(negedge clk) stepReq = 1'b1;
    idle(2);
    cyc(1'b1);
    idle(5);
    chk("R7", "held step no repeat", coreReady, 1'b0);
    @(negedge clk) stepReq = 1'b0;
    idle(2);

    // R11 priority
    curReq = "R11";
    @(negedge clk); runReq = 1; stepReq = 1; slowIn = 1;
    @(negedge clk); runReq = 0; stepReq = 0; slowIn = 0;
    chk("R11", "run wins", runMode, 1'b1);
    pulse(stopReq); cyc(1'b0); idle(2);
    @(negedge clk); stepReq = 1; slowIn = 1;
    @(negedge clk); stepReq = 0; slowIn = 0;
    idle(1);
    cyc(1'b0);
    chk("R11", "step wins, one step only", coreReady, 1'b0);
    idle(DIV + 2);
    chk("R11", "no slow pacing", coreReady, 1'b0);

    // R8 slow pacing, irregular cycle gaps, both granularities
    curReq = "R8";
    instrGran = 1'b0;
    @(negedge clk) slowIn = 1'b1;
    @(negedge clk);
    chk("R8", "first slow release", coreReady, 1'b1);
    idle(2); cyc(1'b0);
    chk("R8", "slow step ended", coreReady, 1'b0);
    idle(3); cyc(1'b0); idle(1); cyc(1'b1);
    idle(DIV + 3); cyc(1'b0);
    instrGran = 1'b1;
    idle(DIV - 2); cyc(1'b0); idle(DIV); cyc(1'b1);
    idle(DIV * 2); cyc(1'b1);

    // R9 release slow in the middle of a step
    curReq = "R9";
    for (int k = 0; k < 3 * DIV; k++) begin
      @(negedge clk);
      if (coreReady) break;
    end
    slowIn = 1'b0;
    idle(3);
    chk("R9", "step still in progress", coreReady, 1'b1);
    cyc(1'b1);
    chk("R9", "halted after step", panelEn, 1'b1);
    idle(3 * DIV);
    chk("R9", "no new release", coreReady, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule